// File: doc/BRIEF.md
# Multi-Stage Trigger Sequencer

This block sits between a set of per-stage condition comparators and a capture buffer. It steps through an ordered chain of trigger stages. Each stage waits for its own match input, and the final active stage produces a one-cycle trigger pulse. Software or a neighbouring controller arms the sequencer with a single-cycle `arm` strobe. After the trigger fires, the sequencer goes idle and ignores every match until it is armed again.

The number of stages in use is set by `stage_count` at run time, up to the `MAX_STAGES` value fixed at build time. Any stage other than the first may limit how long it waits: when its timeout is enabled, its match must arrive within a configured number of cycles counted from the cycle the stage is entered. If that window runs out, the chain falls back to the first stage and stays armed.

Top module: `trig_sequencer`

## Requirements
- R1: After reset `cur_stage` is 0, `trig_pulse` is 0, and the sequencer is idle: a match on stage 0 produces no trigger and no stage change until `arm` is strobed.
- R2: A cycle with `arm` high puts the sequencer in the armed state at stage 0 from the next clock, whatever it was doing before, including in the middle of a chain.
- R3: While armed at stage k below the last active stage, `stage_match[k]` high advances `cur_stage` to k+1 at the next clock. A match on any other bit of `stage_match` is ignored. `cur_stage` is a binary stage index.
- R4: While armed at the last active stage, its match raises `trig_pulse` for exactly the next cycle, returns `cur_stage` to 0 and leaves the sequencer idle, so later matches are ignored until the next `arm`.
- R5: `stage_count` is an unsigned number of active stages. A value of 0 acts as 1, and values above `MAX_STAGES` act as `MAX_STAGES`.
- R6: For a stage k of at least 1 with `tmo_enable[k]` set and window N, `cur_stage` reads k for exactly N cycles after entry when no match comes, and then reads 0. Stage 0 never times out, and its enable bit has no effect.
- R7: The window of stage k is the unsigned field `tmo_limit[17*k+16 : 17*k]`. A value of 0 acts as 1, and 65536 is a legal value.
- R8: A match in the last cycle of a window is accepted and takes priority over the timeout.
- R9: With `tmo_enable[k]` clear, stage k waits indefinitely for its match.
- R10: After a timeout the sequencer stays armed, so a stage 0 match advances it again without a new `arm`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| arm | input | 1 | Single-cycle strobe that restarts the chain at stage 0 |
| stage_match | input | MAX_STAGES | Bit k is the condition match of stage k |
| stage_count | input | CNT_W | Number of active stages |
| tmo_enable | input | MAX_STAGES | Bit k enables the timeout window of stage k |
| tmo_limit | input | MAX_STAGES*TMO_W | Packed per-stage window lengths in cycles |
| trig_pulse | output | 1 | One-cycle trigger when the last stage matches |
| cur_stage | output | STAGE_W | Index of the stage currently waiting |

## Verification
A wrong stage register shows on `cur_stage` at the very next clock. It also shows as a trigger that fires early, late or twice, because only the stage in `cur_stage` may consume a match. A timeout counter that drifts by one stays hidden until the end of a window. It then shows as `cur_stage` falling to 0 one cycle early or late, so every window is checked at both its last allowed cycle and the cycle after, including the extremes of 1 and 65536 cycles. A lost idle or armed flag shows only when a match arrives, so matches are driven both after a trigger and after a timeout.

// File: rtl/trig_seq_pkg.sv
package trig_seq_pkg;

  typedef enum logic {
    SEQ_IDLE = 1'b0,
    SEQ_RUN  = 1'b1
  } seq_state_e;

  // Number of stages actually in use: 0 acts as 1, large values clamp.
  function automatic int unsigned clamp_count(int unsigned raw, int unsigned max_n);
    if (raw == 0)
      return 1;
    else if (raw > max_n)
      return max_n;
    else
      return raw;
  endfunction

  // Window length in cycles for a configured limit: 0 acts as 1.
  function automatic int unsigned window_len(int unsigned raw);
    return (raw == 0) ? 1 : raw;
  endfunction

endpackage

// File: rtl/trig_stage_pick.sv
module trig_stage_pick #(
  parameter int MAX_STAGES = 4,
  parameter int STAGE_W    = 2,
  parameter int TMO_W      = 17
) (
  input  logic [STAGE_W-1:0]          stage,
  input  logic [MAX_STAGES-1:0]       match_vec,
  input  logic [MAX_STAGES-1:0]       en_vec,
  input  logic [MAX_STAGES*TMO_W-1:0] limit_vec,
  output logic                        sel_match,
  output logic                        sel_tmo_en,
  output logic [TMO_W-1:0]            sel_limit
);

  logic [TMO_W-1:0] limit_arr [MAX_STAGES];

  for (genvar g = 0; g < MAX_STAGES; g++) begin : g_unpack
    assign limit_arr[g] = limit_vec[g*TMO_W +: TMO_W];
  end

  always_comb begin
    sel_match  = 1'b0;
    sel_tmo_en = 1'b0;
    sel_limit  = '0;
    for (int i = 0; i < MAX_STAGES; i++) begin
      if (32'(stage) == i) begin
        sel_match  = match_vec[i];
        // The first stage carries no timeout.
        sel_tmo_en = (i != 0) && en_vec[i];
        sel_limit  = limit_arr[i];
      end
    end
  end

endmodule

// File: rtl/trig_stage_timer.sv
module trig_stage_timer
  import trig_seq_pkg::*;
#(
  parameter int TMO_W = 17
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic             run,
  input  logic             tmo_en,
  input  logic [TMO_W-1:0] limit,
  output logic             expire
);

  logic [TMO_W-1:0] elapsed;
  logic             at_last;

  // True in the final cycle of the window.
  assign at_last = (32'(elapsed) + 32'd1) >= window_len(32'(limit));
  assign expire  = run && tmo_en && at_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      elapsed <= '0;
    else if (restart)
      elapsed <= '0;
    else if (run && (elapsed != {TMO_W{1'b1}}))
      elapsed <= elapsed + TMO_W'(1);
  end

  // R7: the elapsed count never passes the end of an enabled window.
  assert_window_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (run && tmo_en && !restart) |-> (32'(elapsed) < window_len(32'(limit))));

endmodule

// File: rtl/trig_seq_ctrl.sv
module trig_seq_ctrl
  import trig_seq_pkg::*;
#(
  parameter int MAX_STAGES = 4,
  parameter int STAGE_W    = 2,
  parameter int CNT_W      = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               arm,
  input  logic               sel_match,
  input  logic               expire,
  input  logic [CNT_W-1:0]   stage_count,
  output logic [STAGE_W-1:0] stage,
  output logic               running,
  output logic               restart,
  output logic               trig_pulse
);

  seq_state_e         state_q, state_d;
  logic [STAGE_W-1:0] stage_d;
  logic [STAGE_W-1:0] last_idx;
  logic               at_last_stage;
  logic               advance;
  logic               fire;
  logic               fall_back;

  assign last_idx      = STAGE_W'(clamp_count(32'(stage_count), MAX_STAGES) - 1);
  assign running       = (state_q == SEQ_RUN);
  assign at_last_stage = (stage == last_idx);

  // Named events, in priority order: arm, match, timeout.
  assign fire      = !arm && running && sel_match && at_last_stage;
  assign advance   = !arm && running && sel_match && !at_last_stage;
  assign fall_back = !arm && running && !sel_match && expire;
  assign restart   = arm || fire || advance || fall_back;

  always_comb begin
    state_d = state_q;
    stage_d = stage;
    if (arm) begin
      state_d = SEQ_RUN;
      stage_d = '0;
    end else if (fire) begin
      state_d = SEQ_IDLE;
      stage_d = '0;
    end else if (advance) begin
      stage_d = stage + STAGE_W'(1);
    end else if (fall_back) begin
      stage_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= SEQ_IDLE;
      stage      <= '0;
      trig_pulse <= 1'b0;
    end else begin
      state_q    <= state_d;
      stage      <= stage_d;
      trig_pulse <= fire;
    end
  end

  // R4: the trigger is a single-cycle pulse.
  assert_single_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    trig_pulse |=> !trig_pulse);

  // R4: after a trigger the chain is back at stage 0.
  assert_trigger_home_R4: assert property (@(posedge clk) disable iff (!rst_n)
    trig_pulse |-> (stage == '0));

  // R5: the stage index never passes the last active stage.
  assert_stage_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
    stage <= last_idx);

  // R3: the stage moves by one step forward or back to 0.
  assert_single_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((stage == $past(stage)) || (stage == '0) ||
              (stage == $past(stage) + STAGE_W'(1))));

  // R1: while idle without arm, the stage stays at 0.
  assert_idle_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!running && !arm) |=> (stage == '0 && !trig_pulse));

endmodule

// File: rtl/trig_sequencer.sv
module trig_sequencer
  import trig_seq_pkg::*;
#(
  parameter  int MAX_STAGES = 4,
  parameter  int TMO_W      = 17,
  localparam int STAGE_W    = (MAX_STAGES > 1) ? $clog2(MAX_STAGES) : 1,
  localparam int CNT_W      = $clog2(MAX_STAGES + 1)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        arm,
  input  logic [MAX_STAGES-1:0]       stage_match,
  input  logic [CNT_W-1:0]            stage_count,
  input  logic [MAX_STAGES-1:0]       tmo_enable,
  input  logic [MAX_STAGES*TMO_W-1:0] tmo_limit,
  output logic                        trig_pulse,
  output logic [STAGE_W-1:0]          cur_stage
);

  logic             sel_match;
  logic             sel_tmo_en;
  logic [TMO_W-1:0] sel_limit;
  logic             tmo_expire;
  logic             running;
  logic             restart;

  trig_stage_pick #(
    .MAX_STAGES (MAX_STAGES),
    .STAGE_W    (STAGE_W),
    .TMO_W      (TMO_W)
  ) i_pick (
    .stage      (cur_stage),
    .match_vec  (stage_match),
    .en_vec     (tmo_enable),
    .limit_vec  (tmo_limit),
    .sel_match  (sel_match),
    .sel_tmo_en (sel_tmo_en),
    .sel_limit  (sel_limit)
  );

  trig_stage_timer #(
    .TMO_W (TMO_W)
  ) i_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (restart),
    .run     (running),
    .tmo_en  (sel_tmo_en),
    .limit   (sel_limit),
    .expire  (tmo_expire)
  );

  trig_seq_ctrl #(
    .MAX_STAGES (MAX_STAGES),
    .STAGE_W    (STAGE_W),
    .CNT_W      (CNT_W)
  ) i_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .arm         (arm),
    .sel_match   (sel_match),
    .expire      (tmo_expire),
    .stage_count (stage_count),
    .stage       (cur_stage),
    .running     (running),
    .restart     (restart),
    .trig_pulse  (trig_pulse)
  );

  // R6: the first stage never times out.
  assert_first_stage_free_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_stage == '0) |-> !tmo_expire);

  // R6: an expired window with no match and no arm returns to stage 0.
  assert_timeout_home_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (tmo_expire && !stage_match[cur_stage] && !arm) |=> (cur_stage == '0));

  // R8: a match in the last window cycle still advances the chain.
  assert_match_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (tmo_expire && stage_match[cur_stage] && !arm) |=> (cur_stage != '0 || trig_pulse));

endmodule

// File: tb/test_trig_sequencer.sv
`timescale 1ns/1ps
module test_trig_sequencer;

  localparam int NS = 4;
  localparam int TW = 17;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          arm = 1'b0;
  logic [NS-1:0] stage_match = '0;
  logic [2:0]    stage_count = 3'd1;
  logic [NS-1:0] tmo_enable = '0;
  logic [NS*TW-1:0] tmo_limit = '0;
  logic          trig_pulse;
  logic [1:0]    cur_stage;

  int n_checks = 0;
  int n_fails  = 0;
  int cycles   = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  trig_sequencer #(.MAX_STAGES(NS), .TMO_W(TW)) i_trig_sequencer (
    .clk, .rst_n, .arm, .stage_match, .stage_count,
    .tmo_enable, .tmo_limit, .trig_pulse, .cur_stage
  );

  // Behavioural reference: a countdown of cycles still allowed in the stage.
  int m_stage = 0;
  bit m_armed = 0;
  int m_left  = 0;
  bit m_pulse = 0;

  function automatic int budget(int k);
    int v = int'(tmo_limit[k*TW +: TW]);
    if (v < 1) v = 1;
    return v;
  endfunction

  function automatic int active_stages();
    int c = int'(stage_count);
    if (c < 1) c = 1;
    if (c > NS) c = NS;
    return c;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_stage = 0; m_armed = 0; m_left = 0; m_pulse = 0;
    end else begin
      m_pulse = 0;
      if (arm) begin
        m_armed = 1; m_stage = 0; m_left = budget(0);
      end else if (m_armed) begin
        if (stage_match[m_stage]) begin
          if (m_stage == active_stages() - 1) begin
            m_pulse = 1; m_armed = 0; m_stage = 0;
          end else begin
            m_stage = m_stage + 1; m_left = budget(m_stage);
          end
        end else if (m_stage > 0 && tmo_enable[m_stage]) begin
          if (m_left <= 1) begin
            m_stage = 0; m_left = budget(0);
          end else begin
            m_left = m_left - 1;
          end
        end
      end
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Every-cycle comparison against the reference, away from the edge.
  always @(posedge clk) begin
    #5;
    if (rst_n && !finished) begin
      check(int'(cur_stage) == m_stage, "R3 model cur_stage", int'(cur_stage), m_stage);
      check(trig_pulse == m_pulse, "R4 model trig_pulse", int'(trig_pulse), int'(m_pulse));
    end
  end

  task automatic summary();
    finished = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !finished) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      summary();
    end
  end

  // One clock: return just after the edge settles.
  task automatic cyc();
    @(posedge clk);
    #6;
  endtask

  task automatic expect_state(input int stg, input bit trg, input string tag);
    check(int'(cur_stage) == stg, {tag, " cur_stage"}, int'(cur_stage), stg);
    check(trig_pulse == trg, {tag, " trig_pulse"}, int'(trig_pulse), int'(trg));
  endtask

  task automatic do_arm();
    arm = 1'b1; cyc(); arm = 1'b0;
  endtask

  initial begin
    repeat (3) cyc();
    expect_state(0, 0, "R1 reset");
    rst_n = 1'b1;
    cyc();

    // R1: idle after reset, matches ignored.
    stage_count = 3'd1;
    stage_match = 4'b0001;
    repeat (3) begin cyc(); expect_state(0, 0, "R1 idle match"); end
    stage_match = '0;

    // R2/R3/R4: three-stage chain.
    stage_count = 3'd3;
    do_arm();
    expect_state(0, 0, "R2 armed");
    stage_match = 4'b0001; cyc(); expect_state(1, 0, "R3 advance 0->1");
    stage_match = 4'b0100; cyc(); expect_state(1, 0, "R3 other bit ignored");
    stage_match = 4'b0010; cyc(); expect_state(2, 0, "R3 advance 1->2");
    stage_match = 4'b0100; cyc(); expect_state(0, 1, "R4 trigger");
    stage_match = 4'b0001; cyc(); expect_state(0, 0, "R4 pulse one cycle");
    cyc(); expect_state(0, 0, "R4 idle after trigger");
    stage_match = '0;

    // R2: arm in mid chain restarts.
    do_arm();
    stage_match = 4'b0001; cyc();
    stage_match = 4'b0010; cyc(); expect_state(2, 0, "R2 reach stage 2");
    stage_match = '0; arm = 1'b1; cyc(); arm = 1'b0;
    expect_state(0, 0, "R2 re-arm in mid chain");

    // R5: count 0 acts as 1.
    stage_count = 3'd0;
    do_arm();
    stage_match = 4'b0001; cyc(); expect_state(0, 1, "R5 count zero as one");
    stage_match = '0; cyc();

    // R5: count 7 clamps to four stages.
    stage_count = 3'd7;
    do_arm();
    stage_match = 4'b1111;
    cyc(); expect_state(1, 0, "R5 clamp step1");
    cyc(); expect_state(2, 0, "R5 clamp step2");
    cyc(); expect_state(3, 0, "R5 clamp step3");
    cyc(); expect_state(0, 1, "R5 clamp trigger at stage 3");
    stage_match = '0; cyc();

    // R6/R10/R8: window of 3 on stage 1.
    stage_count = 3'd3;
    tmo_enable = 4'b0011;
    tmo_limit[0*TW +: TW] = 17'd1;
    tmo_limit[1*TW +: TW] = 17'd3;
    do_arm();
    repeat (5) begin cyc(); expect_state(0, 0, "R6 stage 0 no timeout"); end
    stage_match = 4'b0001; cyc(); stage_match = '0;
    expect_state(1, 0, "R6 window entry");
    cyc(); expect_state(1, 0, "R6 window cycle 2");
    cyc(); expect_state(1, 0, "R6 window cycle 3");
    cyc(); expect_state(0, 0, "R6 timeout to stage 0");
    stage_match = 4'b0001; cyc(); stage_match = '0;
    expect_state(1, 0, "R10 still armed after timeout");
    cyc(); cyc();
    stage_match = 4'b0010; cyc(); stage_match = '0;
    expect_state(2, 0, "R8 match in last window cycle");

    // R7: limit 0 acts as 1.
    tmo_limit[1*TW +: TW] = 17'd0;
    do_arm();
    stage_match = 4'b0001; cyc(); stage_match = '0;
    expect_state(1, 0, "R7 limit zero entry");
    cyc(); expect_state(0, 0, "R7 limit zero one cycle");

    // R9: timeout disabled waits indefinitely.
    tmo_enable = 4'b0000;
    stage_match = 4'b0001; cyc(); stage_match = '0;
    repeat (200) cyc();
    expect_state(1, 0, "R9 no timeout when disabled");

    // R7: largest window 65536.
    tmo_enable = 4'b0010;
    tmo_limit[1*TW +: TW] = 17'd65536;
    do_arm();
    stage_match = 4'b0001; cyc(); stage_match = '0;
    repeat (65535) cyc();
    expect_state(1, 0, "R7 window 65536 last cycle");
    cyc(); expect_state(0, 0, "R7 window 65536 expired");

    cyc();
    summary();
  end

endmodule